// File: doc/BRIEF.md
# Bank-Switched Memory Overlay Decoder

This block sits between a 16-bit processor address bus and the memories of a small computer. For every memory access it picks exactly one responder: fast internal RAM, overlay RAM, the native device of that address range (boot ROM, peripheral ROM, cartridge port or memory-mapped I/O), or slow external expansion RAM. The choice depends on the top three address bits and on a small control word.

The control word is held in a bit-addressable latch on a serial I/O bus. Each I/O cycle carries one bit address and one data bit. A write stores the data bit into the addressed latch bit, and a read returns that bit. Software can therefore move overlay RAM over any of four 8 KB regions at run time, or drop the internal RAM so that its range falls back to the external expansion. Writes into an overlaid region land only in overlay RAM, and a flag reports that the native device has been shielded. One further control bit is passed straight out as the enable for the I/O-device wait-state circuit.

Top module: `mem_overlay_ctrl`

## Requirements
- R1: After a synchronous active-low reset, every control bit reads back 0, `wait_en` is 0, and the memory map is the default: native devices in the four overlayable regions and internal RAM elsewhere.
- R2: An I/O write with `io_addr` = 0x0400 + k, for k in 0..7, stores `io_wdata` into control bit k. The new value is visible on the cycle after the write edge. A read (`io_wr` = 0) at that address returns the bit on `io_rdata` in the same cycle.
- R3: An I/O write to any address outside 0x0400..0x0407 changes no control bit. A read at such an address returns 0.
- R4: Control bit 0 overlays 0x0000-0x1FFF, bit 1 overlays 0x4000-0x5FFF, bit 2 overlays 0x6000-0x7FFF and bit 3 overlays 0x8000-0x9FFF. When the bit is 1 an access there selects overlay RAM (`dev_sel[1]`). When the bit is 0 the access selects the native device (`dev_sel[2]`).
- R5: Addresses 0x2000-0x3FFF and 0xA000-0xFFFF select internal RAM (`dev_sel[0]`) while control bit 4 is 0, and external RAM (`dev_sel[3]`) while it is 1.
- R6: With control bits 0 to 3 set, no address in 0x0000-0xFFFF selects a native device, so the whole space is RAM.
- R7: While `mem_req` is 1, exactly one bit of `dev_sel` is 1. While `mem_req` is 0, `dev_sel` is 0.
- R8: `shadow_wr` is 1 exactly when `mem_req` and `mem_wr` are 1 and the access selects overlay RAM. In that case `dev_sel[2]` is 0.
- R9: `wait_en` equals control bit 7. Control bits 5 and 6 store and read back like the others, but they have no effect on `dev_sel`, `shadow_wr` or `wait_en`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| io_addr | input | 16 | Bit address on the serial I/O bus |
| io_wr | input | 1 | I/O bit write strobe |
| io_wdata | input | 1 | Data bit for the write |
| io_rdata | output | 1 | Addressed control bit, 0 outside the window |
| mem_req | input | 1 | Memory access strobe |
| mem_wr | input | 1 | Access is a write |
| mem_addr | input | 16 | Processor memory address |
| dev_sel | output | 4 | One-hot select: [0] internal, [1] overlay, [2] native, [3] external |
| shadow_wr | output | 1 | Write absorbed by overlay RAM; native device shielded |
| wait_en | output | 1 | Enable for the I/O-device wait-state circuit |

## Verification
The properties assume that `io_wr` is a single-cycle strobe with a stable address and data bit at the sampling edge. They also assume that `mem_wr` only has meaning while `mem_req` is high. The bench drives every input on the falling clock edge, so each value is settled at the rising edge. It mixes random I/O writes, both inside and outside the bit window, with random memory probes, some of them idle, so that every access pattern meets those assumptions. Directed sequences walk each region under the default map, the fully overlaid map, internal-RAM fallback, and the reserved and wait-state bits.

// File: rtl/ovl_pkg.sv
// Package ovl_pkg
// Shared constants for the overlay decoder: control bit positions, device
// select indices and the region-to-overlay-bit map.
// Assumes 8 KB regions selected by the top address bits.
package ovl_pkg;

    localparam int CTRL_BITS   = 8;
    localparam int NOVL        = 4;     // overlayable regions
    localparam int INT_DIS_BIT = 4;
    localparam int WAIT_BIT    = 7;

    localparam int NDEV        = 4;
    localparam int DEV_INT     = 0;
    localparam int DEV_OVL     = 1;
    localparam int DEV_NAT     = 2;
    localparam int DEV_EXT     = 3;

    // Overlay enable index that governs region r, or -1 for internal RAM.
    function automatic int region_ovl_bit(input int r);
        case (r)
            0:       return 0;
            2:       return 1;
            3:       return 2;
            4:       return 3;
            default: return -1;
        endcase
    endfunction

endpackage

// File: rtl/ovl_ctrl_latch.sv
// Module ovl_ctrl_latch
// Bit-addressable control latch on the serial I/O bus. A write stores one
// data bit at (io_addr - IO_BASE); a read returns the addressed bit.
// Assumes io_wr is a one-cycle strobe; addresses outside the window are inert.
module ovl_ctrl_latch #(
    parameter int          IO_W      = 16,
    parameter int          CTRL_BITS = 8,
    parameter logic [15:0] IO_BASE   = 16'h0400
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [IO_W-1:0]      io_addr,
    input  logic                 io_wr,
    input  logic                 io_wdata,
    output logic                 io_rdata,
    output logic [CTRL_BITS-1:0] ctrl_q
);
    localparam int IDX_W = $clog2(CTRL_BITS);

    logic [IO_W-1:0]  offset;
    logic             in_win;
    logic [IDX_W-1:0] idx;

    // Offset of the I/O address from the window base, and window membership.
    always_comb begin
        offset = io_addr - IO_W'(IO_BASE);
        in_win = (offset < IO_W'(CTRL_BITS));
        idx    = offset[IDX_W-1:0];
    end

    // Store the addressed bit on an in-window write; clear all on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (io_wr && in_win) begin
            ctrl_q[idx] <= io_wdata;
        end
    end

    // Return the addressed bit, or 0 outside the window.
    always_comb begin
        io_rdata = in_win ? ctrl_q[idx] : 1'b0;
    end

endmodule

// File: rtl/ovl_region_decode.sv
// Module ovl_region_decode
// Chooses the responding device for the current 8 KB region from the overlay
// enables and the internal-RAM disable. Purely combinational.
// Assumes mem_wr is meaningful only while mem_req is high.
module ovl_region_decode #(
    parameter int REGION_W = 3,
    parameter int NOVL     = ovl_pkg::NOVL,
    parameter int NDEV     = ovl_pkg::NDEV
) (
    input  logic                mem_req,
    input  logic                mem_wr,
    input  logic [REGION_W-1:0] region,
    input  logic [NOVL-1:0]     ovl_en,
    input  logic                int_dis,
    output logic [NDEV-1:0]     dev_sel,
    output logic                shadow_wr
);
    localparam int NREG = 1 << REGION_W;
    localparam logic [NDEV-1:0] ONE_INT = NDEV'(1) << ovl_pkg::DEV_INT;
    localparam logic [NDEV-1:0] ONE_OVL = NDEV'(1) << ovl_pkg::DEV_OVL;
    localparam logic [NDEV-1:0] ONE_NAT = NDEV'(1) << ovl_pkg::DEV_NAT;
    localparam logic [NDEV-1:0] ONE_EXT = NDEV'(1) << ovl_pkg::DEV_EXT;

    logic [NDEV-1:0] region_sel [NREG];

    // One owner per region: overlay vs native, or internal vs external RAM.
    for (genvar r = 0; r < NREG; r++) begin : g_region
        if (ovl_pkg::region_ovl_bit(r) >= 0) begin : g_ovl
            assign region_sel[r] = ovl_en[ovl_pkg::region_ovl_bit(r)] ? ONE_OVL : ONE_NAT;
        end else begin : g_ram
            assign region_sel[r] = int_dis ? ONE_EXT : ONE_INT;
        end
    end

    // Gate the region owner with the request strobe; flag absorbed writes.
    always_comb begin
        dev_sel   = mem_req ? region_sel[region] : '0;
        shadow_wr = mem_req && mem_wr && region_sel[region][ovl_pkg::DEV_OVL];
    end

endmodule

// File: rtl/mem_overlay_ctrl.sv
// Module mem_overlay_ctrl
// Top of the overlay decoder: control latch on the I/O bus plus region decode
// on the memory bus. Outputs a one-hot device select, a shielded-write flag
// and the wait-state enable.
// Assumes a 16-bit address space split into 8 KB regions.
module mem_overlay_ctrl #(
    parameter int          ADDR_W   = 16,
    parameter int          IO_W     = 16,
    parameter int          REGION_W = 3,
    parameter logic [15:0] IO_BASE  = 16'h0400
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IO_W-1:0]   io_addr,
    input  logic              io_wr,
    input  logic              io_wdata,
    output logic              io_rdata,
    input  logic              mem_req,
    input  logic              mem_wr,
    input  logic [ADDR_W-1:0] mem_addr,
    output logic [3:0]        dev_sel,
    output logic              shadow_wr,
    output logic              wait_en
);
    localparam int CTRL_BITS = ovl_pkg::CTRL_BITS;
    localparam int NOVL      = ovl_pkg::NOVL;

    logic [CTRL_BITS-1:0]    ctrl_q;
    logic [REGION_W-1:0]     region;
    logic                    unused_addr_lo;

    // Region index from the top address bits; offset bits are not decoded.
    always_comb begin
        region         = mem_addr[ADDR_W-1 -: REGION_W];
        unused_addr_lo = ^mem_addr[ADDR_W-REGION_W-1:0];
    end

    ovl_ctrl_latch #(
        .IO_W      (IO_W),
        .CTRL_BITS (CTRL_BITS),
        .IO_BASE   (IO_BASE)
    ) u_latch (
        .clk      (clk),
        .rst_n    (rst_n),
        .io_addr  (io_addr),
        .io_wr    (io_wr),
        .io_wdata (io_wdata),
        .io_rdata (io_rdata),
        .ctrl_q   (ctrl_q)
    );

    ovl_region_decode #(
        .REGION_W (REGION_W),
        .NOVL     (NOVL),
        .NDEV     (4)
    ) u_decode (
        .mem_req   (mem_req),
        .mem_wr    (mem_wr),
        .region    (region),
        .ovl_en    (ctrl_q[NOVL-1:0]),
        .int_dis   (ctrl_q[ovl_pkg::INT_DIS_BIT]),
        .dev_sel   (dev_sel),
        .shadow_wr (shadow_wr)
    );

    // Wait-state enable is the latched control bit, passed straight out.
    always_comb begin
        wait_en = ctrl_q[ovl_pkg::WAIT_BIT];
    end

endmodule

// File: rtl/ovl_ctrl_chk.sv
// Module ovl_ctrl_chk
// Property checker bound to mem_overlay_ctrl. Observes ports and the latched
// control word. Assumes one-cycle I/O write strobes.
module ovl_ctrl_chk #(
    parameter int          IO_W    = 16,
    parameter logic [15:0] IO_BASE = 16'h0400
) (
    input logic            clk,
    input logic            rst_n,
    input logic [IO_W-1:0] io_addr,
    input logic            io_wr,
    input logic            io_wdata,
    input logic            mem_req,
    input logic            mem_wr,
    input logic [3:0]      dev_sel,
    input logic            shadow_wr,
    input logic            wait_en,
    input logic [7:0]      ctrl_q
);
    logic [IO_W-1:0] off;
    logic            in_win;

    // Window membership computed independently of the latch.
    always_comb begin
        off    = io_addr - IO_W'(IO_BASE);
        in_win = (off < IO_W'(8));
    end

    // R2
    readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (io_wr && in_win) |=> ctrl_q[$past(off[2:0])] == $past(io_wdata));

    // R3
    outside_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (io_wr && !in_win) |=> $stable(ctrl_q));

    // R7
    one_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> $countones(dev_sel) == 1);

    // R7
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_req |-> dev_sel == 4'b0000);

    // R8
    no_writethrough_chk: assert property (@(posedge clk) disable iff (!rst_n)
        shadow_wr |-> (mem_req && mem_wr && dev_sel[1] && !dev_sel[2]));

    // R8
    shadow_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_wr && dev_sel[1]) |-> shadow_wr);

    // R9
    wait_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (io_wr && io_addr == IO_W'(IO_BASE) + IO_W'(7)) |=> wait_en == $past(io_wdata));

endmodule

bind mem_overlay_ctrl ovl_ctrl_chk #(
    .IO_W    (IO_W),
    .IO_BASE (IO_BASE)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .io_addr   (io_addr),
    .io_wr     (io_wr),
    .io_wdata  (io_wdata),
    .mem_req   (mem_req),
    .mem_wr    (mem_wr),
    .dev_sel   (dev_sel),
    .shadow_wr (shadow_wr),
    .wait_en   (wait_en),
    .ctrl_q    (ctrl_q)
);

// File: tb/test_mem_overlay_ctrl.sv
// Bench for mem_overlay_ctrl: directed corners plus seeded random traffic,
// compared against a bench-side model of the control word and memory map.
module test_mem_overlay_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] io_addr = '0;
    logic        io_wr = 1'b0;
    logic        io_wdata = 1'b0;
    logic        io_rdata;
    logic        mem_req = 1'b0;
    logic        mem_wr = 1'b0;
    logic [15:0] mem_addr = '0;
    logic [3:0]  dev_sel;
    logic        shadow_wr;
    logic        wait_en;

    int   checks = 0;
    int   errors = 0;
    bit   done = 0;
    logic [7:0] model = '0;

    always #10 clk = ~clk;   // 50 MHz

    mem_overlay_ctrl i_mem_overlay_ctrl (
        .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr),
        .io_wdata(io_wdata), .io_rdata(io_rdata), .mem_req(mem_req),
        .mem_wr(mem_wr), .mem_addr(mem_addr), .dev_sel(dev_sel),
        .shadow_wr(shadow_wr), .wait_en(wait_en)
    );

    function automatic logic [3:0] exp_sel(logic [7:0] c, logic [15:0] a, logic req);
        int ob;
        if (!req) return 4'b0000;
        case (a[15:13])
            3'd0: ob = 0;
            3'd2: ob = 1;
            3'd3: ob = 2;
            3'd4: ob = 3;
            default: ob = -1;
        endcase
        if (ob >= 0) return c[ob] ? 4'b0010 : 4'b0100;
        return c[4] ? 4'b1000 : 4'b0001;
    endfunction

    function automatic logic exp_shadow(logic [7:0] c, logic [15:0] a, logic req, logic wr);
        return req && wr && exp_sel(c, a, req)[1];
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic io_write(logic [15:0] a, logic d);
        @(negedge clk);
        io_addr = a; io_wdata = d; io_wr = 1'b1;
        @(negedge clk);
        io_wr = 1'b0;
        if (a >= 16'h0400 && a <= 16'h0407) model[a - 16'h0400] = d;
    endtask

    task automatic mem_probe(string tag, logic [15:0] a, logic req, logic wr);
        @(negedge clk);
        mem_addr = a; mem_req = req; mem_wr = wr;
        #2;
        check({tag, " dev_sel"}, 32'(dev_sel), 32'(exp_sel(model, a, req)));
        check({tag, " shadow_wr"}, 32'(shadow_wr), 32'(exp_shadow(model, a, req, wr)));
        mem_req = 1'b0; mem_wr = 1'b0;
    endtask

    task automatic rd_probe(string tag, logic [15:0] a);
        logic e;
        @(negedge clk);
        io_addr = a; io_wr = 1'b0;
        #2;
        e = (a >= 16'h0400 && a <= 16'h0407) ? model[a - 16'h0400] : 1'b0;
        check(tag, 32'(io_rdata), 32'(e));
    endtask

    task automatic summary();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            summary();
            $finish;
        end
    end

    initial begin
        int unsigned seed_dummy;
        seed_dummy = $urandom(32'd20240611);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        for (int k = 0; k < 8; k++) rd_probe("R1 reset readback", 16'h0400 + 16'(k));
        #1 check("R1 wait_en after reset", 32'(wait_en), 32'd0);
        for (int r = 0; r < 8; r++) mem_probe("R1 default map", 16'(r) << 13, 1'b1, 1'b0);

        // R7: idle request selects nothing
        mem_probe("R7 idle", 16'h2000, 1'b0, 1'b1);

        // R2 / R4 / R8: each overlay bit in turn
        for (int b = 0; b < 4; b++) begin
            io_write(16'h0400 + 16'(b), 1'b1);
            rd_probe("R2 readback set", 16'h0400 + 16'(b));
            for (int r = 0; r < 8; r++) mem_probe("R4 R8 single overlay write", (16'(r) << 13) | 16'h0123, 1'b1, 1'b1);
            io_write(16'h0400 + 16'(b), 1'b0);
            rd_probe("R2 readback clear", 16'h0400 + 16'(b));
        end

        // R6: all overlays on, no native device anywhere
        for (int b = 0; b < 4; b++) io_write(16'h0400 + 16'(b), 1'b1);
        for (int r = 0; r < 8; r++) begin
            mem_probe("R6 all RAM", (16'(r) << 13) | 16'h1FFF, 1'b1, 1'b0);
            check("R6 native off", 32'(exp_sel(model, 16'(r) << 13, 1'b1)[2]), 32'd0);
        end

        // R5: internal RAM disable falls back to external
        io_write(16'h0404, 1'b1);
        mem_probe("R5 ext low", 16'h2000, 1'b1, 1'b0);
        mem_probe("R5 ext high", 16'hFFFF, 1'b1, 1'b1);
        io_write(16'h0404, 1'b0);
        mem_probe("R5 int back", 16'hA000, 1'b1, 1'b0);

        // R3: writes just outside the window are ignored
        io_write(16'h0408, 1'b1);
        io_write(16'h03FF, 1'b1);
        io_write(16'h0000, 1'b0);
        rd_probe("R3 read outside", 16'h0408);
        for (int k = 0; k < 8; k++) rd_probe("R3 window unchanged", 16'h0400 + 16'(k));
        mem_probe("R3 map unchanged", 16'h0000, 1'b1, 1'b1);

        // R9: reserved bits inert, bit 7 drives wait_en
        io_write(16'h0405, 1'b1);
        io_write(16'h0406, 1'b1);
        rd_probe("R9 reserved readback", 16'h0406);
        #1 check("R9 wait_en unaffected", 32'(wait_en), 32'd0);
        for (int r = 0; r < 8; r++) mem_probe("R9 reserved no effect", 16'(r) << 13, 1'b1, 1'b1);
        io_write(16'h0407, 1'b1);
        #1 check("R9 wait_en set", 32'(wait_en), 32'd1);
        io_write(16'h0407, 1'b0);
        #1 check("R9 wait_en clear", 32'(wait_en), 32'd0);

        // Random traffic across R2 R3 R4 R5 R7 R8 R9
        for (int i = 0; i < 600; i++) begin
            case ($urandom_range(0, 3))
                0: io_write(16'h0400 + 16'($urandom_range(0, 7)), 1'($urandom_range(0, 1)));
                1: io_write(16'($urandom_range(0, 65535)), 1'($urandom_range(0, 1)));
                2: mem_probe("R7 R8 random access", 16'($urandom_range(0, 65535)),
                             1'($urandom_range(0, 4) != 0), 1'($urandom_range(0, 1)));
                default: rd_probe("R2 random readback", 16'h03FE + 16'($urandom_range(0, 11)));
            endcase
            if (i % 50 == 0) begin
                #1 check("R9 random wait_en", 32'(wait_en), 32'(model[7]));
            end
        end

        done = 1;
        summary();
        $finish;
    end

endmodule